// File: doc/BRIEF.md
# Expansion-to-Host Memory Forwarding Decoder

This block sits on the expansion-bus side of a bus bridge. For every memory cycle it looks at the 32-bit address and decides whether the bridge claims the cycle and passes it to the host PCI bus. The decision draws on three sources. The first is a fixed map of the first megabyte, whose ROM and BIOS areas can be switched on in 16 KByte pieces. The second is a programmable main-memory range with an optional hole cut out of it. The third is a set of general address windows. A 64 KByte window just below 16 MByte follows its own rule: it is forwarded whenever it lies in main memory, and otherwise only when its enable bit is set. The top 2 MByte of the 4 GByte space is never main memory, so it reaches PCI only through a general window.

Software loads the configuration through a simple register write port. The expansion-bus controller pulses an address strobe together with the address. One clock later the block presents a one-cycle valid flag, the claim decision and a code that says which rule made the claim. The result stays on the outputs until the next strobe.

Top module: `mem_fwd_decoder`

## Requirements
- R1: After reset every enable is cleared, the top-of-memory field is zero (main memory is empty, which is the same as a top of 1 MByte) and there is no hole. A strobed decode of any address then returns claim 0 and class 0.
- R2: A decode is captured on the rising edge where `addrStrobe` is high. In the cycle that follows, `fwdValid` is 1. It is 0 after any edge where `addrStrobe` was low, and `fwdClaim` and `hitClass` then keep their values.
- R3: Register 1, bits 31:21, holds the top of memory T in 2 MByte units. An address A with 1 MByte <= A < T*2 MByte that is outside the hole is claimed with class 1 (main). The largest value T=2047 places the top at 4 GByte minus 2 MByte.
- R4: Register 2 defines the hole. Bits 15:0 give the base and bits 31:16 give the size, both in 64 KByte units. An address with base <= A[31:16] < base+size is not main memory. A size of zero means there is no hole.
- R5: Below 1 MByte, register 0 holds the enable bits of the fixed areas: bit 0 for 0–512K, bit 1 for 512–640K, bit 2 for 640–768K (video) and bit 15 for 960K–1M. An address in an enabled area is claimed with class 2.
- R6: Bits 3+k (k=0..7) of register 0 enable the 16 KByte section k of 768–896K, with k = A[16:14]. Bits 11+j (j=0..3) enable section j of 896–960K, with j = A[15:14]. Each section is claimed only when its own bit is set.
- R7: An address in FF0000h–FFFFFFh that lies in main memory is claimed with class 1, whatever the value of register 0 bit 16.
- R8: An address in FF0000h–FFFFFFh that is above the top of memory or inside the hole is claimed with class 3 when register 0 bit 16 is set. When that bit is clear, the address is not claimed.
- R9: Registers 4..7 hold windows 0..3. Bits 15:0 give the base and bits 31:16 give the limit, both as A[31:16]. Register 8, bits 3:0, enables each window. An address with base <= A[31:16] <= limit in an enabled window is claimed with class 4.
- R10: Addresses from FFE00000h upward are never claimed unless an enabled general window covers them.
- R11: When several rules hit, the class follows the priority main (1) > low map (2) > below-16M window (3) > general window (4). `fwdClaim` is 1 exactly when the class is not 0.
- R12: A write takes effect for strobes on later edges. A strobe on the same edge as a write uses the previous configuration. Writes to register addresses 3 and 9..15 change no decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 4 | Configuration register number |
| cfgData | input | 32 | Configuration write data |
| addrStrobe | input | 1 | Address strobe; captures a decode |
| memAddr | input | 32 | Expansion-side memory address |
| fwdValid | output | 1 | One-cycle flag after a strobe |
| fwdClaim | output | 1 | Cycle is forwarded to PCI |
| hitClass | output | 3 | Rule that claimed: 0 none, 1 main, 2 low map, 3 below-16M window, 4 general window |

## Verification
A table of addresses is decoded against one fixed configuration. The addresses are placed just inside and just outside every section edge of the first megabyte, at both ends of the hole, around the top of memory and at the edges of each window. Together they show whether each boundary comparison is off by one and whether each enable bit is tied to the correct section. Directed sequences then reprogram the top of memory and the hole so that the 16 MByte window moves between three states: in main memory, above the top and inside the hole. Each state is tried with its enable bit set and clear. These sequences also enable a window over the top 2 MByte, overlap a window with main memory to test the class priority, and place a write on the same edge as a strobe.

// File: rtl/mem_fwd_pkg.sv
package mem_fwd_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int CFG_AW      = 4;
  localparam int NUM_WIN     = 4;
  localparam int ROM_SECTS   = 8;
  localparam int LBIOS_SECTS = 4;
  localparam int PAGE_W      = 16;            // 64 KByte granule index width
  localparam int TOM_W       = ADDR_W - 21;   // 2 MByte granule index width
  localparam int LOW_EN_W    = 3 + ROM_SECTS + LBIOS_SECTS + 1;

  localparam logic [CFG_AW-1:0] REG_LOWMAP = 4'd0;
  localparam logic [CFG_AW-1:0] REG_TOM    = 4'd1;
  localparam logic [CFG_AW-1:0] REG_HOLE   = 4'd2;
  localparam logic [CFG_AW-1:0] REG_WIN0   = 4'd4;
  localparam logic [CFG_AW-1:0] REG_WINEN  = 4'd8;

  localparam logic [PAGE_W-1:0] PAGE_BELOW16M = 16'h00FF;
  localparam logic [TOM_W-1:0]  TOP_RESERVED  = '1;  // last 2 MByte of space

  typedef enum logic [2:0] {
    CLS_NONE     = 3'd0,
    CLS_MAIN     = 3'd1,
    CLS_LOW      = 3'd2,
    CLS_BELOW16M = 3'd3,
    CLS_WINDOW   = 3'd4
  } hitClass_e;

  typedef struct packed {
    logic [LOW_EN_W-1:0]              lowEn;
    logic                             w16En;
    logic [TOM_W-1:0]                 tomUnits;
    logic [PAGE_W-1:0]                holeBase;
    logic [PAGE_W-1:0]                holeSize;
    logic [NUM_WIN-1:0]               winEn;
    logic [NUM_WIN-1:0][PAGE_W-1:0]   winBase;
    logic [NUM_WIN-1:0][PAGE_W-1:0]   winLimit;
  } cfg_t;

  typedef struct packed {
    logic capture;   // latch a new decode this edge
    logic retire;    // drop the valid flag this edge
  } strobe_t;
endpackage

// File: rtl/mem_fwd_ctrl.sv
module mem_fwd_ctrl
  import mem_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              addrStrobe,
  output cfg_t              cfg,
  output strobe_t           strobes
);
  logic [LOW_EN_W-1:0]            lowEnQ;
  logic                           w16EnQ;
  logic [TOM_W-1:0]               tomQ;
  logic [PAGE_W-1:0]              holeBaseQ;
  logic [PAGE_W-1:0]              holeSizeQ;
  logic [NUM_WIN-1:0]             winEnQ;
  logic [NUM_WIN-1:0][PAGE_W-1:0] winBaseQ;
  logic [NUM_WIN-1:0][PAGE_W-1:0] winLimitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowEnQ    <= '0;
      w16EnQ    <= 1'b0;
      tomQ      <= '0;
      holeBaseQ <= '0;
      holeSizeQ <= '0;
      winEnQ    <= '0;
    end else if (cfgWrEn) begin
      unique case (cfgAddr)
        REG_LOWMAP: begin
          lowEnQ <= cfgData[LOW_EN_W-1:0];
          w16EnQ <= cfgData[LOW_EN_W];
        end
        REG_TOM:   tomQ <= cfgData[DATA_W-1 -: TOM_W];
        REG_HOLE: begin
          holeBaseQ <= cfgData[PAGE_W-1:0];
          holeSizeQ <= cfgData[2*PAGE_W-1:PAGE_W];
        end
        REG_WINEN: winEnQ <= cfgData[NUM_WIN-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winBaseQ  <= '0;
      winLimitQ <= '0;
    end else if (cfgWrEn) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (cfgAddr == REG_WIN0 + CFG_AW'(i)) begin
          winBaseQ[i]  <= cfgData[PAGE_W-1:0];
          winLimitQ[i] <= cfgData[2*PAGE_W-1:PAGE_W];
        end
      end
    end
  end

  always_comb begin
    cfg.lowEn    = lowEnQ;
    cfg.w16En    = w16EnQ;
    cfg.tomUnits = tomQ;
    cfg.holeBase = holeBaseQ;
    cfg.holeSize = holeSizeQ;
    cfg.winEn    = winEnQ;
    cfg.winBase  = winBaseQ;
    cfg.winLimit = winLimitQ;
    strobes.capture = addrStrobe;
    strobes.retire  = !addrStrobe;
  end
endmodule

// File: rtl/mem_fwd_lowmap.sv
module mem_fwd_lowmap
  import mem_fwd_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LOW_EN_W-1:0] lowEn,
  output logic                lowHit
);
  localparam int ROM_IDX_W = $clog2(ROM_SECTS);
  localparam int LB_IDX_W  = $clog2(LBIOS_SECTS);
  localparam int ROM_BIT0  = 3;
  localparam int LB_BIT0   = ROM_BIT0 + ROM_SECTS;

  logic                below1M;
  logic [LOW_EN_W-1:0] secHit;

  assign below1M = (addr[ADDR_W-1:20] == '0);

  // Fixed areas: base memory, 512-640K, video, upper BIOS.
  assign secHit[0]          = below1M && !addr[19];
  assign secHit[1]          = below1M && (addr[19:17] == 3'b100);
  assign secHit[2]          = below1M && (addr[19:17] == 3'b101);
  assign secHit[LOW_EN_W-1] = below1M && (addr[19:16] == 4'hF);

  // 16 KByte expansion ROM sections, 768-896K.
  for (genvar g = 0; g < ROM_SECTS; g++) begin : g_rom
    assign secHit[ROM_BIT0+g] = below1M && (addr[19:17] == 3'b110) &&
                                (addr[14 +: ROM_IDX_W] == ROM_IDX_W'(g));
  end

  // 16 KByte lower BIOS sections, 896-960K.
  for (genvar h = 0; h < LBIOS_SECTS; h++) begin : g_lbios
    assign secHit[LB_BIT0+h] = below1M && (addr[19:16] == 4'hE) &&
                               (addr[14 +: LB_IDX_W] == LB_IDX_W'(h));
  end

  assign lowHit = |(secHit & lowEn);
endmodule

// File: rtl/mem_fwd_window.sv
module mem_fwd_window
  import mem_fwd_pkg::*;
(
  input  logic              winEn,
  input  logic [PAGE_W-1:0] winBase,
  input  logic [PAGE_W-1:0] winLimit,
  input  logic [PAGE_W-1:0] addrPage,
  output logic              winHit
);
  assign winHit = winEn && (addrPage >= winBase) && (addrPage <= winLimit);
endmodule

// File: rtl/mem_fwd_dp.sv
module mem_fwd_dp
  import mem_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              fwdValid,
  output logic              fwdClaim,
  output hitClass_e         hitClass
);
  logic [PAGE_W-1:0]  addrPage;
  logic [PAGE_W:0]    holeEnd;
  logic               inHole;
  logic               aboveLow;
  logic               belowTop;
  logic               inMain;
  logic               lowHit;
  logic               is16M;
  logic               w16Fwd;
  logic [NUM_WIN-1:0] winHits;
  logic               winAny;
  logic               claimD;
  hitClass_e          classD;

  assign addrPage = memAddr[ADDR_W-1 -: PAGE_W];
  assign holeEnd  = {1'b0, cfg.holeBase} + {1'b0, cfg.holeSize};
  assign inHole   = (cfg.holeSize != '0) && (addrPage >= cfg.holeBase) &&
                    ({1'b0, addrPage} < holeEnd);
  assign aboveLow = (memAddr[ADDR_W-1:20] != '0);
  assign belowTop = (memAddr[ADDR_W-1 -: TOM_W] < cfg.tomUnits);
  assign inMain   = aboveLow && belowTop && !inHole;
  assign is16M    = (addrPage == PAGE_BELOW16M);
  assign w16Fwd   = is16M && cfg.w16En;

  mem_fwd_lowmap uLowmap (
    .addr   (memAddr),
    .lowEn  (cfg.lowEn),
    .lowHit (lowHit)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mem_fwd_window uWin (
      .winEn    (cfg.winEn[w]),
      .winBase  (cfg.winBase[w]),
      .winLimit (cfg.winLimit[w]),
      .addrPage (addrPage),
      .winHit   (winHits[w])
    );
  end
  assign winAny = |winHits;

  assign claimD = inMain || lowHit || w16Fwd || winAny;

  always_comb begin
    if (inMain)      classD = CLS_MAIN;
    else if (lowHit) classD = CLS_LOW;
    else if (w16Fwd) classD = CLS_BELOW16M;
    else if (winAny) classD = CLS_WINDOW;
    else             classD = CLS_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdClaim <= 1'b0;
      hitClass <= CLS_NONE;
    end else begin
      if (strobes.capture) begin
        fwdValid <= 1'b1;
        fwdClaim <= claimD;
        hitClass <= classD;
      end else if (strobes.retire) begin
        fwdValid <= 1'b0;
      end
    end
  end

  // R2: result holds while no strobe arrives
  p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(fwdClaim) && $stable(hitClass) && !fwdValid));

  // R11: claim flag agrees with the class code
  p_claim_class_agree_r11: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdClaim == (hitClass != CLS_NONE)));

  // R4: hole addresses reached by no other rule are not forwarded
  p_hole_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && inHole && !winAny && !lowHit && !w16Fwd) |=> !fwdClaim);

  // R10: the top 2 MByte only goes out through a general window
  p_top_region_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (memAddr[ADDR_W-1 -: TOM_W] == TOP_RESERVED) && !winAny)
      |=> !fwdClaim);

  // R7: the below-16M page in main memory is always forwarded as main
  p_w16_main_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && is16M && belowTop && !inHole) |=> (hitClass == CLS_MAIN));
endmodule

// File: rtl/mem_fwd_decoder.sv
module mem_fwd_decoder
  import mem_fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgAddr,
  input  logic [31:0] cfgData,
  input  logic        addrStrobe,
  input  logic [31:0] memAddr,
  output logic        fwdValid,
  output logic        fwdClaim,
  output logic [2:0]  hitClass
);
  cfg_t      cfg;
  strobe_t   strobes;
  hitClass_e classQ;

  mem_fwd_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .addrStrobe (addrStrobe),
    .cfg        (cfg),
    .strobes    (strobes)
  );

  mem_fwd_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .strobes  (strobes),
    .memAddr  (memAddr),
    .fwdValid (fwdValid),
    .fwdClaim (fwdClaim),
    .hitClass (classQ)
  );

  assign hitClass = classQ;
endmodule

// File: tb/mem_fwd_decoder_test.sv
module mem_fwd_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        addrStrobe = 1'b0;
  logic [31:0] memAddr = '0;
  logic        fwdValid;
  logic        fwdClaim;
  logic [2:0]  hitClass;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mem_fwd_decoder uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .addrStrobe(addrStrobe), .memAddr(memAddr),
    .fwdValid(fwdValid), .fwdClaim(fwdClaim), .hitClass(hitClass)
  );

  // {address, expected claim, expected class, requirement number}
  localparam int NUM_VEC = 23;
  localparam logic [39:0] VECS [0:NUM_VEC-1] = '{
    {32'h0001_0000, 1'b0, 3'd0, 4'd5},  // R5 base area disabled
    {32'h0008_1000, 1'b1, 3'd2, 4'd5},  // R5 512-640K enabled
    {32'h000A_0000, 1'b0, 3'd0, 4'd5},  // R5 video disabled
    {32'h000C_4000, 1'b1, 3'd2, 4'd6},  // R6 ROM section 1 start
    {32'h000C_0000, 1'b0, 3'd0, 4'd6},  // R6 ROM section 0 off
    {32'h000C_7FFF, 1'b1, 3'd2, 4'd6},  // R6 ROM section 1 end
    {32'h000C_8000, 1'b0, 3'd0, 4'd6},  // R6 ROM section 2 off
    {32'h000E_4000, 1'b1, 3'd2, 4'd6},  // R6 lower BIOS section 1
    {32'h000E_8000, 1'b0, 3'd0, 4'd6},  // R6 lower BIOS section 2 off
    {32'h000F_8000, 1'b1, 3'd2, 4'd5},  // R5 upper BIOS
    {32'h0010_0000, 1'b1, 3'd1, 4'd11}, // R11 main beats window 3
    {32'h001F_FFFF, 1'b1, 3'd1, 4'd3},  // R3 main below hole
    {32'h0020_0000, 1'b0, 3'd0, 4'd4},  // R4 hole start
    {32'h002F_FFFF, 1'b0, 3'd0, 4'd4},  // R4 hole end
    {32'h0030_0000, 1'b1, 3'd1, 4'd4},  // R4 first page after hole
    {32'h00FF_0000, 1'b1, 3'd1, 4'd7},  // R7 below-16M in main, bit clear
    {32'h0100_0000, 1'b0, 3'd0, 4'd3},  // R3 at top of memory
    {32'h2000_0000, 1'b1, 3'd4, 4'd9},  // R9 window 0 base
    {32'h2FFF_FFFF, 1'b1, 3'd4, 4'd9},  // R9 window 0 limit page end
    {32'h3000_0000, 1'b0, 3'd0, 4'd9},  // R9 window 2 disabled
    {32'hFFE0_0000, 1'b0, 3'd0, 4'd10}, // R10 top region, window off
    {32'hFFFF_FFFC, 1'b0, 3'd0, 4'd10}, // R10 top region end
    {32'h1FFF_FFFF, 1'b0, 3'd0, 4'd9}   // R9 just below window 0
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic decode(input logic [31:0] a, input logic expClaim,
                        input logic [2:0] expCls, input int req);
    @(negedge clk);
    addrStrobe = 1'b1; memAddr = a;
    @(negedge clk);
    addrStrobe = 1'b0;
    chk(req, "valid", 32'(fwdValid), 32'd1);
    chk(req, $sformatf("claim @%h", a), 32'(fwdClaim), 32'(expClaim));
    chk(req, $sformatf("class @%h", a), 32'(hitClass), 32'(expCls));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "valid at reset", 32'(fwdValid), 32'd0);
    chk(1, "claim at reset", 32'(fwdClaim), 32'd0);
    rstN = 1'b1;
    decode(32'h0010_0000, 1'b0, 3'd0, 1);  // R1 no main memory
    decode(32'h000F_0000, 1'b0, 3'd0, 1);  // R1 low map off
    decode(32'h00FF_0000, 1'b0, 3'd0, 1);  // R1 below-16M off
    decode(32'hFFF0_0000, 1'b0, 3'd0, 1);  // R1 no windows

    cfgWrite(4'd0, 32'h0000_9012);
    cfgWrite(4'd1, 32'h0100_0000);   // top = 16 MByte
    cfgWrite(4'd2, 32'h0010_0020);   // hole 2M..3M
    cfgWrite(4'd4, 32'h2FFF_2000);
    cfgWrite(4'd5, 32'hFFFF_FFE0);
    cfgWrite(4'd6, 32'h3000_3000);
    cfgWrite(4'd7, 32'h0010_0010);
    cfgWrite(4'd8, 32'h0000_0009);

    for (int i = 0; i < NUM_VEC; i++)
      decode(VECS[i][39:8], VECS[i][7], VECS[i][6:4], int'(VECS[i][3:0]));

    // R2 valid drops, result holds
    decode(32'h0010_0000, 1'b1, 3'd1, 2);
    @(negedge clk);
    chk(2, "valid after idle", 32'(fwdValid), 32'd0);
    chk(2, "claim held", 32'(fwdClaim), 32'd1);
    chk(2, "class held", 32'(hitClass), 32'd1);

    // R12 unused register numbers change nothing
    cfgWrite(4'd3, 32'hFFFF_FFFF);
    for (int r = 9; r < 16; r++) cfgWrite(4'(r), 32'hFFFF_FFFF);
    decode(32'h000A_0000, 1'b0, 3'd0, 12);
    decode(32'h3000_0000, 1'b0, 3'd0, 12);
    decode(32'h0030_0000, 1'b1, 3'd1, 12);
    decode(32'h0100_0000, 1'b0, 3'd0, 12);

    // R12 write on the strobe edge uses the old configuration
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'd8; cfgData = 32'h0000_000D;
    addrStrobe = 1'b1; memAddr = 32'h3000_0000;
    @(negedge clk);
    cfgWrEn = 1'b0; addrStrobe = 1'b0;
    chk(12, "same-edge claim", 32'(fwdClaim), 32'd0);
    decode(32'h3000_0000, 1'b1, 3'd4, 12);

    // R10 top region through an enabled window
    cfgWrite(4'd8, 32'h0000_000F);
    decode(32'hFFE0_0000, 1'b1, 3'd4, 10);
    cfgWrite(4'd8, 32'h0000_0009);

    // R7 enable bit set while in main: still main class
    cfgWrite(4'd0, 32'h0001_9012);
    decode(32'h00FF_0000, 1'b1, 3'd1, 7);

    // R8 above top of memory
    cfgWrite(4'd1, 32'h0080_0000);   // top = 8 MByte
    decode(32'h00FF_8000, 1'b1, 3'd3, 8);
    cfgWrite(4'd0, 32'h0000_9012);
    decode(32'h00FF_8000, 1'b0, 3'd0, 8);

    // R8 inside the hole
    cfgWrite(4'd1, 32'h0100_0000);
    cfgWrite(4'd2, 32'h0001_00FF);
    decode(32'h00FF_0000, 1'b0, 3'd0, 8);
    decode(32'h00FE_FFFF, 1'b1, 3'd1, 4);
    cfgWrite(4'd0, 32'h0001_9012);
    decode(32'h00FF_FFFF, 1'b1, 3'd3, 8);

    // R4 size zero removes the hole
    cfgWrite(4'd2, 32'h0000_0020);
    decode(32'h0020_0000, 1'b1, 3'd1, 4);

    // R3 largest top of memory
    cfgWrite(4'd1, 32'hFFE0_0000);
    decode(32'hFFDF_FFFC, 1'b1, 3'd1, 3);
    decode(32'hFFE0_0000, 1'b0, 3'd0, 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule